// File: doc/BRIEF.md
# Stuck-Cell Masking Write Unit

This unit sits between a requester and a single-port memory whose data cells may be permanently stuck at 0 or at 1. Each 64-bit word is split into eight 8-bit partitions. For each partition, the unit writes either the true bits or their complement. It picks whichever form puts the value a known bad cell already holds into that cell. One invert flag per partition is stored beside the data. On a read, each partition is XORed with its flag, so the requester always sees the original word.

The unit learns faults by checking every write. After it writes a word, it reads the same address back and compares the data bits with what it sent. If any bit differs, it takes the lowest differing bit position and the value that came back, and stores them with the address in an eight-entry fault cache. Entries are replaced in round-robin order. It then retries the write once with flags recomputed from the updated cache. Faults that are already cached are handled on the first attempt, so a known bad cell costs no extra write. If two cached faults in the same partition need opposite polarities, the word cannot be stored correctly, and the unit reports this as uncorrectable.

Top module: `stuck_inv_write_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `done`, `fault` and `uncorr` are 0, and the fault cache holds no entries.
- R2: A write to an address with no cached fault stores the data unchanged, with all eight flags 0. The stored word is `{flags[7:0], data[63:0]}`, and flag p covers data bits `8p+7:8p`.
- R3: A read returns the stored data with every partition p XORed with stored flag bit `64+p`. `done` pulses for one cycle with the result on `rd_data`.
- R4: Every write is followed in the next cycle by a read of the same address. If the data bits differ, the lowest differing bit position and its read-back value are cached for that address. The write is then reissued with recomputed flags.
- R5: A write that meets only cached faults at its address is correct on the first attempt and issues one memory write.
- R6: For a cached fault at bit b with stuck value s, the flag of partition b/8 is `data[b] ^ s`. Partitions with no cached fault get flag 0.
- R7: If two cached faults in one partition need opposite flags, `uncorr` is 1 when `done` pulses. Two faults in one partition that need the same flag raise no `uncorr`.
- R8: A write issues at most two memory writes. If the second verify still differs, `done` pulses with `fault` = 1.
- R9: The fault cache holds eight entries, filled and replaced in round-robin order. The ninth learned fault evicts the first.
- R10: `req_ready` is 1 only while the unit is idle, and goes to 0 in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read result, valid with `done` after a read |
| fault | output | 1 | Write failed verify after its retry |
| uncorr | output | 1 | Flag conflict in the final write attempt |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W+DATA_W/PART_W | Flags above data, to memory |
| mem_rdata | input | DATA_W+DATA_W/PART_W | Memory read data, one cycle after a read |

## Verification
The hardest condition to reach is a real flag conflict. It needs two cached faults at one address, in one partition, with opposite polarities, and both must be learned one at a time through failed verifies. The bench gives the memory model two adjacent stuck cells of opposite values. It writes zeros once, so the first attempt learns one cell and the retry exposes the other. It then writes zeros again, which forces the conflict. Eviction is reached by giving nine different addresses one stuck cell each. Writes to an early address and to the evicted address then show one and two memory writes respectively.

// File: rtl/stuck_inv_write_unit.sv
module stuck_inv_write_unit #(
  parameter int DATA_W  = 64,
  parameter int PART_W  = 8,
  parameter int CACHE_N = 8,
  parameter int ADDR_W  = 8,
  localparam int NPART  = DATA_W / PART_W,
  localparam int WORD_W = DATA_W + NPART
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault,
  output logic              uncorr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int POS_W  = $clog2(DATA_W);
  localparam int PW_LOG = $clog2(PART_W);
  localparam int PTR_W  = $clog2(CACHE_N);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_VRD, S_VCHK, S_RD, S_RRSP} state_t;
  state_t st;

  logic [ADDR_W-1:0]  a_q;
  logic [DATA_W-1:0]  d_q, sent_q;
  logic               retry_q, conf_q;
  logic [CACHE_N-1:0] c_vld, c_val;
  logic [ADDR_W-1:0]  c_addr [CACHE_N];
  logic [POS_W-1:0]   c_pos  [CACHE_N];
  logic [PTR_W-1:0]   rr_q;

  logic [NPART-1:0]   need_set, need_clr;
  logic [DATA_W-1:0]  enc, dec, mism;
  logic [POS_W-1:0]   first;

  always_comb begin
    need_set = '0;
    need_clr = '0;
    for (int e = 0; e < CACHE_N; e++)
      if (c_vld[e] && c_addr[e] == a_q)
        for (int p = 0; p < NPART; p++)
          if (int'(c_pos[e] >> PW_LOG) == p) begin
            if (d_q[c_pos[e]] ^ c_val[e]) need_set[p] = 1'b1;
            else                         need_clr[p] = 1'b1;
          end
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    assign enc[p*PART_W +: PART_W] = d_q[p*PART_W +: PART_W] ^ {PART_W{need_set[p]}};
    assign dec[p*PART_W +: PART_W] = mem_rdata[p*PART_W +: PART_W] ^ {PART_W{mem_rdata[DATA_W+p]}};
  end

  assign mism = mem_rdata[DATA_W-1:0] ^ sent_q;

  always_comb begin
    first = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (mism[i]) first = POS_W'(i);
  end

  assign req_ready = (st == S_IDLE);
  assign mem_en    = (st == S_WR) || (st == S_VRD) || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = a_q;
  assign mem_wdata = {need_set, enc};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      d_q     <= '0;
      sent_q  <= '0;
      retry_q <= 1'b0;
      conf_q  <= 1'b0;
      c_vld   <= '0;
      c_val   <= '0;
      rr_q    <= '0;
      done    <= 1'b0;
      fault   <= 1'b0;
      uncorr  <= 1'b0;
      rd_data <= '0;
      for (int e = 0; e < CACHE_N; e++) begin
        c_addr[e] <= '0;
        c_pos[e]  <= '0;
      end
    end else begin
      done   <= 1'b0;
      fault  <= 1'b0;
      uncorr <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q     <= req_addr;
          d_q     <= req_wdata;
          retry_q <= 1'b0;
          st      <= req_write ? S_WR : S_RD;
        end
        S_WR: begin
          sent_q <= enc;
          conf_q <= |(need_set & need_clr);
          st     <= S_VRD;
        end
        S_VRD: st <= S_VCHK;
        S_VCHK: begin
          if (|mism) begin
            c_vld[rr_q]  <= 1'b1;
            c_addr[rr_q] <= a_q;
            c_pos[rr_q]  <= first;
            c_val[rr_q]  <= mem_rdata[first];
            rr_q <= (rr_q == PTR_W'(CACHE_N - 1)) ? '0 : rr_q + 1'b1;
            if (!retry_q) begin
              retry_q <= 1'b1;
              st      <= S_WR;
            end else begin
              done   <= 1'b1;
              fault  <= 1'b1;
              uncorr <= conf_q;
              st     <= S_IDLE;
            end
          end else begin
            done   <= 1'b1;
            uncorr <= conf_q;
            st     <= S_IDLE;
          end
        end
        S_RD: st <= S_RRSP;
        S_RRSP: begin
          rd_data <= dec;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stuck_inv_write_unit_chk.sv
module stuck_inv_write_unit_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              fault,
  input logic              uncorr,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= '0;
    else if (req_valid && req_ready) wcnt <= '0;
    else if (mem_en && mem_we && wcnt != 2'd3) wcnt <= wcnt + 2'd1;
  end

  p_verify_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (mem_en && !mem_we && mem_addr == $past(mem_addr)));

  p_two_writes_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> (wcnt < 2'd2));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_uncorr_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uncorr |-> done);

  p_fault_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en);
endmodule

bind stuck_inv_write_unit stuck_inv_write_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .fault(fault), .uncorr(uncorr),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/stuck_inv_write_unit_test.sv
module stuck_inv_write_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, done, fault, uncorr, mem_en, mem_we;
  logic [63:0] rd_data;
  logic [7:0]  mem_addr;
  logic [71:0] mem_wdata;
  logic [71:0] mem_rdata = '0;

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [71:0] mem [256];
  logic [63:0] smask [256];
  logic [63:0] sval [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_addr = '0;
  logic [71:0] poke_data = '0;

  always #4 clk = ~clk;

  stuck_inv_write_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .fault(fault), .uncorr(uncorr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    else if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= {mem_wdata[71:64],
          (mem_wdata[63:0] & ~smask[mem_addr]) | (sval[mem_addr] & smask[mem_addr])};
        wr_cnt <= wr_cnt + 1;
      end else mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 50) begin
      @(negedge clk);
      k++;
    end
    if (!done) chk("timeout", 72'd0, 72'd1);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [63:0] d,
                          output int nw, output logic f, output logic u, output logic busy);
    int n0;
    @(negedge clk);
    n0 = wr_cnt;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy = !req_ready;
    wait_done();
    f = fault; u = uncorr;
    nw = wr_cnt - n0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    d = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 ready", 72'(req_ready), 72'd1);
    chk("R1 done", 72'(done), 72'd0);
    chk("R1 fault/uncorr", 72'({fault, uncorr}), 72'd0);
  endtask

  task automatic t_plain();
    int nw; logic f, u, b; logic [63:0] r;
    logic [63:0] d = 64'hA5A5_3C3C_0F0F_1234;
    do_write(8'd1, d, nw, f, u, b);
    chk("R10 busy after accept", 72'(b), 72'd1);
    chk("R2 one write", 72'(nw), 72'd1);
    chk("R2 stored word", mem[1], {8'h00, d});
    chk("R2 no fault", 72'({f, u}), 72'd0);
    do_read(8'd1, r);
    chk("R3 read plain", 72'(r), 72'(d));
  endtask

  task automatic t_read_decode();
    logic [63:0] d = 64'h0123_4567_89AB_CDEF, m = '0, r;
    logic [7:0] fl = 8'hA5;
    for (int p = 0; p < 8; p++) if (fl[p]) m[p*8 +: 8] = 8'hFF;
    @(negedge clk);
    poke_en = 1'b1; poke_addr = 8'd5; poke_data = {fl, d ^ m};
    @(negedge clk);
    poke_en = 1'b0;
    do_read(8'd5, r);
    chk("R3 read undoes flags", 72'(r), 72'(d));
  endtask

  task automatic t_learn();
    int nw; logic f, u, b; logic [63:0] r;
    logic [63:0] d = 64'hFEDC_BA98_7654_0000;
    do_write(8'd10, d, nw, f, u, b);
    chk("R4 retry after mismatch", 72'(nw), 72'd2);
    chk("R4 no fault after retry", 72'({f, u}), 72'd0);
    chk("R4 stored inverted partition", mem[10], {8'h02, d ^ 64'h0000_0000_0000_FF00});
    do_read(8'd10, r);
    chk("R4 read back", 72'(r), 72'(d));
  endtask

  task automatic t_reuse();
    int nw; logic f, u, b; logic [63:0] r;
    logic [63:0] d2 = 64'h1111_2222_3333_0044;
    logic [63:0] d3 = 64'h0000_0000_0000_2000;
    do_write(8'd10, d2, nw, f, u, b);
    chk("R5 cached fault one write", 72'(nw), 72'd1);
    chk("R6 flag set for opposite data", 72'(mem[10][71:64]), 72'h02);
    do_read(8'd10, r);
    chk("R5 read back", 72'(r), 72'(d2));
    do_write(8'd10, d3, nw, f, u, b);
    chk("R6 flag clear for matching data", mem[10], {8'h00, d3});
    chk("R5 matching data one write", 72'(nw), 72'd1);
  endtask

  task automatic t_conflict();
    int nw; logic f, u, b;
    do_write(8'd20, 64'd0, nw, f, u, b);
    chk("R8 second fault unseen two writes", 72'(nw), 72'd2);
    chk("R8 fault after retry", 72'({f, u}), 72'b10);
    do_write(8'd20, 64'd0, nw, f, u, b);
    chk("R7 opposite polarity uncorr", 72'({f, u}), 72'b11);
    chk("R8 still two writes", 72'(nw), 72'd2);
    do_write(8'd20, 64'h0000_0000_0001_0000, nw, f, u, b);
    chk("R7 same polarity no uncorr", 72'({f, u}), 72'b00);
    chk("R7 same polarity one write", 72'(nw), 72'd1);
  endtask

  task automatic t_evict();
    int nw; logic f, u, b;
    do_reset();
    for (int k = 0; k < 9; k++) begin
      do_write(8'(100 + k), 64'd0, nw, f, u, b);
      chk("R1 empty cache learns", 72'(nw), 72'd2);
    end
    do_write(8'd102, 64'd0, nw, f, u, b);
    chk("R9 retained entry", 72'(nw), 72'd1);
    do_write(8'd100, 64'd0, nw, f, u, b);
    chk("R9 evicted entry relearned", 72'(nw), 72'd2);
    chk("R9 relearned no fault", 72'(f), 72'd0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      smask[a] = '0;
      sval[a]  = '0;
    end
    smask[10] = 64'h2000;  sval[10] = 64'h2000;
    smask[20] = 64'h3_0000; sval[20] = 64'h1_0000;
    for (int k = 0; k < 9; k++) begin
      smask[100 + k] = 64'd1 << (k * 7);
      sval[100 + k]  = 64'd1 << (k * 7);
    end
    do_reset();
    t_reset();
    t_plain();
    t_read_decode();
    t_learn();
    t_reuse();
    t_conflict();
    t_evict();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule